// File: doc/BRIEF.md
# Password-Gated Register Write Guard

This block decides whether writes to a group of protected control registers may go through. It watches a simple register-bus write port. A write to one dedicated guard address carries a 5-bit code in its low bits. Only three code values mean anything. One unlocks the protected registers, one locks them again, and one loads a new protection mode from the top data bit. Any other code leaves the guard exactly as it was.

Writes that land inside the protected address window come out as a registered write strobe, with a window-relative index and the data. This happens only while the guard permits it. A blocked write disappears, so the protected registers keep their contents. The mode selects between enforcing, where the lock applies, and bypass, where protected writes always pass. Two status outputs report the lock state and the mode.

Top module: `pw_write_guard`

## Requirements
- R1: After synchronous reset, access_open is 0, mode_bypass is 0 (enforcing mode), and prot_we is 0.
- R2: A write to GUARD_ADDR whose data bits [4:0] equal 5'b10011 sets access_open to 1 in the cycle after the write edge.
- R3: A write to GUARD_ADDR whose data bits [4:0] equal 5'b10101 clears access_open to 0 in the cycle after the write edge.
- R4: A write to GUARD_ADDR whose data bits [4:0] equal 5'b11000 loads mode_bypass from data bit DATA_W-1 (1 = bypass, 0 = enforcing). The open/closed state is not changed.
- R5: A guard write whose bits [4:0] hold any other value changes neither access_open nor mode_bypass. The open and close codes do not touch the mode, whatever the upper data bits hold.
- R6: With access closed and the enforcing mode selected, a write into the protected window produces no prot_we pulse, and the protected register keeps its value.
- R7: With access open, a write into the protected window gives one prot_we pulse in the cycle after the write edge. prot_idx is the address minus PROT_BASE and prot_data is the written data. Access stays open afterwards.
- R8: In bypass mode, a write into the protected window is passed as in R7 even while access is closed.
- R9: Only addresses from PROT_BASE to PROT_BASE+PROT_COUNT-1 inclusive produce prot_we. Writes just outside the window, and writes to GUARD_ADDR, never do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data; bits [4:0] are the code on guard writes, bit DATA_W-1 the mode value |
| prot_we | output | 1 | Registered write enable for the protected registers |
| prot_idx | output | IDX_W | Index of the protected register within the window |
| prot_data | output | DATA_W | Data for the protected register |
| access_open | output | 1 | 1 while protected writes are unlocked |
| mode_bypass | output | 1 | 1 while the guard is in bypass mode |

## Verification
Reaching a protected write in bypass mode while the lock is closed takes the hardest setup. The mode code must be sent with the top data bit set, and no unlock code may come before it. The stimulus closes access first, loads the bypass mode, writes into the window, and then returns to the enforcing mode to show that the same write is dropped again. Codes that sit one bit away from the valid ones, and valid codes carrying stray upper bits, are sent to show that only the five low bits decide.

// File: rtl/pw_guard_pkg.sv
package pw_guard_pkg;

  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] CODE_OPEN  = 5'b10011;
  localparam logic [CODE_W-1:0] CODE_CLOSE = 5'b10101;
  localparam logic [CODE_W-1:0] CODE_MODE  = 5'b11000;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_OPEN  = 2'd1,
    CMD_CLOSE = 2'd2,
    CMD_MODE  = 2'd3
  } pw_cmd_e;

endpackage

// File: rtl/pw_cmd_decode.sv
module pw_cmd_decode
  import pw_guard_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int GUARD_ADDR = 'hF0,
  parameter int PROT_BASE  = 'h10,
  parameter int PROT_COUNT = 4,
  parameter int IDX_W      = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output pw_cmd_e           cmd,
  output logic              mode_val,
  output logic              is_prot,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W:0]   BASE_X  = (ADDR_W+1)'(PROT_BASE);
  localparam logic [ADDR_W:0]   LIMIT_X = (ADDR_W+1)'(PROT_BASE + PROT_COUNT);
  localparam logic [ADDR_W-1:0] GUARD_A = ADDR_W'(GUARD_ADDR);

  logic              is_guard;
  logic [CODE_W-1:0] code;
  logic [ADDR_W-1:0] offset;
  logic              unused_bits;

  assign is_guard = wr_en && (wr_addr == GUARD_A);
  assign code     = wr_data[CODE_W-1:0];
  assign mode_val = wr_data[DATA_W-1];

  always_comb begin
    cmd = CMD_NONE;
    if (is_guard) begin
      unique case (code)
        CODE_OPEN:  cmd = CMD_OPEN;
        CODE_CLOSE: cmd = CMD_CLOSE;
        CODE_MODE:  cmd = CMD_MODE;
        default:    cmd = CMD_NONE;
      endcase
    end
  end

  assign is_prot = wr_en && ({1'b0, wr_addr} >= BASE_X) && ({1'b0, wr_addr} < LIMIT_X);
  assign offset  = wr_addr - BASE_X[ADDR_W-1:0];
  assign idx     = offset[IDX_W-1:0];

  assign unused_bits = ^{offset, wr_data};

endmodule

// File: rtl/pw_guard_state.sv
module pw_guard_state
  import pw_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  pw_cmd_e cmd,
  input  logic    mode_val,
  output logic    open_q,
  output logic    bypass_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      bypass_q <= 1'b0;
    end else begin
      case (cmd)
        CMD_OPEN:  open_q   <= 1'b1;
        CMD_CLOSE: open_q   <= 1'b0;
        CMD_MODE:  bypass_q <= mode_val;
        default:   ;
      endcase
    end
  end

  assert_open_by_code_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> $past(cmd == CMD_OPEN));

  assert_open_takes_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_OPEN) |=> open_q);

  assert_close_takes_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CLOSE) |=> !open_q);

  assert_mode_by_code_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(bypass_q) |-> $past(cmd == CMD_MODE));

  assert_idle_code_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NONE) |=> ($stable(open_q) && $stable(bypass_q)));

endmodule

// File: rtl/pw_write_gate.sv
module pw_write_gate #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_prot,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              open_q,
  input  logic              bypass_q,
  output logic              prot_we,
  output logic [IDX_W-1:0]  prot_idx,
  output logic [DATA_W-1:0] prot_data
);

  logic permit;
  assign permit = is_prot && (open_q || bypass_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_we   <= 1'b0;
      prot_idx  <= '0;
      prot_data <= '0;
    end else begin
      prot_we <= permit;
      if (permit) begin
        prot_idx  <= idx;
        prot_data <= wr_data;
      end
    end
  end

  assert_locked_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (is_prot && !open_q && !bypass_q) |=> !prot_we);

  assert_open_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (is_prot && open_q) |=> (prot_we && prot_data == $past(wr_data) && prot_idx == $past(idx)));

  assert_bypass_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (is_prot && bypass_q) |=> prot_we);

  assert_window_only_R9: assert property (@(posedge clk) disable iff (rst)
    prot_we |-> $past(is_prot));

endmodule

// File: rtl/pw_write_guard.sv
module pw_write_guard
  import pw_guard_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int GUARD_ADDR = 'hF0,
  parameter int PROT_BASE  = 'h10,
  parameter int PROT_COUNT = 4,
  localparam int IDX_W     = (PROT_COUNT > 1) ? $clog2(PROT_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prot_we,
  output logic [IDX_W-1:0]  prot_idx,
  output logic [DATA_W-1:0] prot_data,
  output logic              access_open,
  output logic              mode_bypass
);

  pw_cmd_e          cmd;
  logic             mode_val;
  logic             is_prot;
  logic [IDX_W-1:0] idx;
  logic             open_q;
  logic             bypass_q;

  pw_cmd_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GUARD_ADDR(GUARD_ADDR),
    .PROT_BASE(PROT_BASE), .PROT_COUNT(PROT_COUNT), .IDX_W(IDX_W)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd(cmd), .mode_val(mode_val), .is_prot(is_prot), .idx(idx)
  );

  pw_guard_state u_state (
    .clk(clk), .rst(rst), .cmd(cmd), .mode_val(mode_val),
    .open_q(open_q), .bypass_q(bypass_q)
  );

  pw_write_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst(rst), .is_prot(is_prot), .idx(idx), .wr_data(wr_data),
    .open_q(open_q), .bypass_q(bypass_q),
    .prot_we(prot_we), .prot_idx(prot_idx), .prot_data(prot_data)
  );

  assign access_open = open_q;
  assign mode_bypass = bypass_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!access_open && !mode_bypass && !prot_we));

endmodule

// File: tb/sim_pw_write_guard.sv
module sim_pw_write_guard;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       prot_we;
  logic [1:0] prot_idx;
  logic [7:0] prot_data;
  logic       access_open;
  logic       mode_bypass;
  logic [7:0] ex_reg;
  int         checks = 0;
  int         fails = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  pw_write_guard u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prot_we(prot_we), .prot_idx(prot_idx), .prot_data(prot_data),
    .access_open(access_open), .mode_bypass(mode_bypass)
  );

  // Example protected register at window index 1
  always_ff @(posedge clk) begin
    if (rst) ex_reg <= 8'h00;
    else if (prot_we && prot_idx == 2'd1) ex_reg <= prot_data;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 open", access_open, 0);
    check("R1 bypass", mode_bypass, 0);
    check("R1 we", prot_we, 0);
  endtask

  task automatic t_locked();
    bus_wr(8'h11, 8'h5A);
    check("R6 we", prot_we, 0);
    @(negedge clk);
    check("R6 reg", ex_reg, 8'h00);
  endtask

  task automatic t_open();
    bus_wr(8'hF0, 8'h13);
    check("R2 open", access_open, 1);
    check("R2 bypass", mode_bypass, 0);
    bus_wr(8'h11, 8'hA5);
    check("R7 we", prot_we, 1);
    check("R7 idx", prot_idx, 1);
    check("R7 data", prot_data, 8'hA5);
    @(negedge clk);
    check("R7 reg", ex_reg, 8'hA5);
    check("R7 one pulse", prot_we, 0);
    check("R7 stays open", access_open, 1);
  endtask

  task automatic t_codes();
    bus_wr(8'hF0, 8'h93);
    check("R5 open code keeps mode", mode_bypass, 0);
    bus_wr(8'hF0, 8'h14);
    bus_wr(8'hF0, 8'h1F);
    check("R5 junk keeps open", access_open, 1);
    bus_wr(8'hF0, 8'h95);
    check("R3 closed", access_open, 0);
    check("R3 mode kept", mode_bypass, 0);
    bus_wr(8'hF0, 8'h07);
    bus_wr(8'hF0, 8'hF4);
    bus_wr(8'hF0, 8'h1B);
    check("R5 junk keeps closed", access_open, 0);
    check("R5 junk keeps mode", mode_bypass, 0);
    bus_wr(8'h11, 8'h66);
    @(negedge clk);
    check("R5 reg after junk", ex_reg, 8'hA5);
  endtask

  task automatic t_bypass();
    bus_wr(8'hF0, 8'h98);
    check("R4 bypass set", mode_bypass, 1);
    check("R4 open untouched", access_open, 0);
    bus_wr(8'h13, 8'h77);
    check("R8 we", prot_we, 1);
    check("R8 idx", prot_idx, 3);
    check("R8 data", prot_data, 8'h77);
    bus_wr(8'hF0, 8'h18);
    check("R4 bypass clear", mode_bypass, 0);
    bus_wr(8'h11, 8'h42);
    check("R6 we again", prot_we, 0);
    @(negedge clk);
    check("R6 reg again", ex_reg, 8'hA5);
  endtask

  task automatic t_window();
    bus_wr(8'hF0, 8'h13);
    bus_wr(8'h14, 8'h01);
    check("R9 above", prot_we, 0);
    bus_wr(8'h0F, 8'h02);
    check("R9 below", prot_we, 0);
    bus_wr(8'hF0, 8'h1F);
    check("R9 guard", prot_we, 0);
    bus_wr(8'h10, 8'h03);
    check("R9 base we", prot_we, 1);
    check("R9 base idx", prot_idx, 0);
  endtask

  initial begin
    t_reset();
    t_locked();
    t_open();
    t_codes();
    t_bypass();
    t_window();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule